// File: doc/BRIEF.md
# Bit-Timing Recovery DPLL

This block rebuilds the receive bit clock of a 1200 bit/s serial link from a hard-decision data stream that has already been demodulated. It runs on the fast master clock (3.6864 MHz by default, 3072 master cycles per bit). A free-running bit-phase counter sets the local bit timing. Each level change on the incoming data gives a phase measurement against the point where the counter wraps, which is where a transition ideally falls. The block then moves the counter toward that point by a small or a large correction.

Two static inputs shape the loop.

- `fast_corr_i` enables the proportional large correction. This correction applies only while the measured error is wider than 1/16 of a bit, which is 22.5 degrees.
- `slow_lock_i` picks the small step. It is 6 counts for the quick lock-in profile (18 bits) and 2 counts for the steady profile (50 bits).

The recovered clock `rt_o` is high in the first half of each bit and low in the second half. The data output `rd_o` is the synchronized input sampled at mid-bit. It changes in the same master cycle as the `rt_o` falling edge.

Internally the two halves of the bit are a two-state machine. `PH_HIGH` holds while the counter is below half a bit and drives `rt_o` high. `PH_LOW` holds while the counter is in the upper half and drives `rt_o` low. The transition `PH_HIGH`→`PH_LOW` happens when the counter reaches mid-bit and captures the data bit. The transition `PH_LOW`→`PH_HIGH` happens when the counter wraps.

Top module: `bit_timing_dpll`

## Requirements
- R1: With no input transitions, `rt_o` is periodic with exactly CNT_PER_BIT master cycles per period. It is high for the first CNT_PER_BIT/2 cycles after each rising edge.
- R2: `rd_o` changes only in the master-clock cycle in which `rt_o` falls, with no extra cycle of delay.
- R3: At each `rt_o` falling edge, `rd_o` takes the level that `rx_bit_i` held at the rising master-clock edge two cycles before that falling edge (two-flop synchronizer).
- R4: A level change on `rx_bit_i` is located by a phase count c. c equals one plus the number of master cycles from the latest `rt_o` rising edge to the first rising edge at which the new level is present. The error magnitude m is c when c < CNT_PER_BIT/2, and CNT_PER_BIT − c otherwise.
- R5: The direction of the correction follows from c. For c < CNT_PER_BIT/2 the counter is retarded, and for c ≥ CNT_PER_BIT/2 it is advanced. With a single transition, the span from an `rt_o` rise to the second following rise is 2·CNT_PER_BIT + step when retarding and 2·CNT_PER_BIT − step when advancing.
- R6: With `fast_corr_i` = 1 and m > CNT_PER_BIT/16, the step is floor(m/8).
- R7: With `fast_corr_i` = 1 and m ≤ CNT_PER_BIT/16 (boundary included), the small step is used.
- R8: With `fast_corr_i` = 0, only the small step is used, whatever the size of m.
- R9: The small step is 6 counts when `slow_lock_i` = 0 and 2 counts when `slow_lock_i` = 1. No step exceeds m.
- R10: With `fast_corr_i` = 1 and an alternating pattern at the nominal rate from any starting phase, m is within CNT_PER_BIT/16 by the 18th transition when `slow_lock_i` = 0 and by the 50th when `slow_lock_i` = 1. It stays there afterwards.
- R11: During reset, `rt_o` is 1, `rd_o` is 0 and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, CNT_PER_BIT cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Demodulated hard-decision data, asynchronous |
| fast_corr_i | input | 1 | 1 enables large proportional correction outside the window |
| slow_lock_i | input | 1 | 0 selects small step 6 (quick profile), 1 selects small step 2 |
| rt_o | output | 1 | Recovered bit clock, high in the first half of the bit |
| rd_o | output | 1 | Retimed data, updated on the falling edge of `rt_o` |

## Verification
A corrupted phase counter or a wrong wrap value shows on `rt_o` within one bit, as a period or high time other than CNT_PER_BIT and CNT_PER_BIT/2. A wrong step size, a wrong direction or a misplaced window threshold shows in the bit that follows the offending transition. It appears as a two-bit `rt_o` span that differs from 2·CNT_PER_BIT ± step. A misplaced sampling point shows as an `rd_o` change away from the `rt_o` fall, or as a wrong level, at the very next mid-bit. Errors in the sweep between profiles show as an error outside the window once the 18-bit or 50-bit budget has run out.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    // Kind of correction applied to the bit-phase counter in one cycle
    typedef enum logic [1:0] {
        CORR_NONE,
        CORR_SMALL,
        CORR_LARGE
    } corr_e;

    // Direction of a correction
    typedef enum logic {
        DIR_ADVANCE,
        DIR_RETARD
    } dir_e;

    // Half of the bit the counter is in; drives the recovered clock
    typedef enum logic {
        PH_HIGH,
        PH_LOW
    } half_e;

endpackage

// File: rtl/dpll_edge_sync.sv
module dpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o,
    output logic edge_o
);

    // chain_q[STAGES-1] is the synchronized bit, chain_q[STAGES] its delayed copy
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din_i};
        end
    end

    assign dout_o = chain_q[STAGES-1];
    assign edge_o = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
    import dpll_pkg::*;
#(
    parameter  int CNT_PER_BIT = 3072,
    parameter  int LOCK_WIN    = 192,
    parameter  int LARGE_SHIFT = 3,
    parameter  int SMALL_QUICK = 6,
    parameter  int SMALL_SLOW  = 2,
    localparam int CW          = $clog2(CNT_PER_BIT)
) (
    input  logic [CW-1:0] cnt_i,
    input  logic          edge_i,
    input  logic          fast_i,
    input  logic          slow_i,
    output corr_e         kind_o,
    output dir_e          dir_o,
    output logic [CW-1:0] mag_o,
    output logic [CW-1:0] step_o
);

    localparam int HALF = CNT_PER_BIT / 2;

    logic          late;
    logic          large_sel;
    logic [CW-1:0] mag;
    logic [CW-1:0] small_step;
    logic [CW-1:0] raw_step;
    logic [CW-1:0] step;

    always_comb begin
        // Ideal transition sits at the counter wrap; fold into a distance
        late       = (cnt_i < CW'(HALF));
        mag        = late ? cnt_i : (CW'(CNT_PER_BIT) - cnt_i);
        small_step = slow_i ? CW'(SMALL_SLOW) : CW'(SMALL_QUICK);
        large_sel  = fast_i && (mag > CW'(LOCK_WIN));
        raw_step   = large_sel ? (mag >> LARGE_SHIFT) : small_step;
        // Never step past the ideal point
        step       = (raw_step > mag) ? mag : raw_step;

        dir_o = late ? DIR_RETARD : DIR_ADVANCE;
        if (!edge_i || (step == '0)) begin
            kind_o = CORR_NONE;
        end else if (large_sel) begin
            kind_o = CORR_LARGE;
        end else begin
            kind_o = CORR_SMALL;
        end
        step_o = (kind_o == CORR_NONE) ? '0 : step;
        mag_o  = mag;
    end

endmodule

// File: rtl/dpll_bit_ctr.sv
module dpll_bit_ctr
    import dpll_pkg::*;
#(
    parameter  int CNT_PER_BIT = 3072,
    localparam int CW          = $clog2(CNT_PER_BIT)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  corr_e         kind_i,
    input  dir_e          dir_i,
    input  logic [CW-1:0] step_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o
);

    localparam logic [CW:0] WRAP = (CW+1)'(CNT_PER_BIT);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   base;
    logic [CW:0]   sum;

    always_comb begin
        base = {1'b0, cnt_q} + 1'b1;
        case (kind_i)
            CORR_SMALL, CORR_LARGE: begin
                if (dir_i == DIR_ADVANCE) begin
                    sum = base + {1'b0, step_i};
                end else begin
                    sum = base - {1'b0, step_i};
                end
            end
            default: sum = base;
        endcase
        cnt_nxt_o = (sum >= WRAP) ? CW'(sum - WRAP) : CW'(sum);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bit_timing_dpll.sv
module bit_timing_dpll
    import dpll_pkg::*;
#(
    parameter int CNT_PER_BIT = 3072,
    parameter int SYNC_STAGES = 2,
    parameter int LARGE_SHIFT = 3,
    parameter int SMALL_QUICK = 6,
    parameter int SMALL_SLOW  = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_bit_i,
    input  logic fast_corr_i,
    input  logic slow_lock_i,
    output logic rt_o,
    output logic rd_o
);

    localparam int CW       = $clog2(CNT_PER_BIT);
    localparam int HALF     = CNT_PER_BIT / 2;
    localparam int LOCK_WIN = CNT_PER_BIT / 16;   // 22.5 of 360 degrees

    logic          data_s;
    logic          edge_s;
    corr_e         corr_kind;
    dir_e          corr_dir;
    logic [CW-1:0] err_mag;
    logic [CW-1:0] corr_step;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    half_e         half_q;
    half_e         half_nxt;
    logic          take_sample;
    logic          rd_q;

    dpll_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (rx_bit_i),
        .dout_o (data_s),
        .edge_o (edge_s)
    );

    dpll_phase_det #(
        .CNT_PER_BIT (CNT_PER_BIT),
        .LOCK_WIN    (LOCK_WIN),
        .LARGE_SHIFT (LARGE_SHIFT),
        .SMALL_QUICK (SMALL_QUICK),
        .SMALL_SLOW  (SMALL_SLOW)
    ) u_det (
        .cnt_i  (cnt_q),
        .edge_i (edge_s),
        .fast_i (fast_corr_i),
        .slow_i (slow_lock_i),
        .kind_o (corr_kind),
        .dir_o  (corr_dir),
        .mag_o  (err_mag),
        .step_o (corr_step)
    );

    dpll_bit_ctr #(
        .CNT_PER_BIT (CNT_PER_BIT)
    ) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .kind_i    (corr_kind),
        .dir_i     (corr_dir),
        .step_i    (corr_step),
        .cnt_o     (cnt_q),
        .cnt_nxt_o (cnt_nxt)
    );

    // Next-state logic for the bit-half state machine
    always_comb begin
        half_nxt    = half_q;
        take_sample = 1'b0;
        unique case (half_q)
            PH_HIGH: begin
                if (cnt_nxt >= CW'(HALF)) begin
                    half_nxt    = PH_LOW;
                    take_sample = 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt_nxt < CW'(HALF)) begin
                    half_nxt = PH_HIGH;
                end
            end
        endcase
    end

    // State register and mid-bit data capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= PH_HIGH;
            rd_q   <= 1'b0;
        end else begin
            half_q <= half_nxt;
            if (take_sample) begin
                rd_q <= data_s;
            end
        end
    end

    // Outputs
    always_comb begin
        rt_o = (half_q == PH_HIGH);
        rd_o = rd_q;
    end

endmodule

// File: rtl/bit_timing_dpll_chk.sv
module bit_timing_dpll_chk #(
    parameter  int CNT_PER_BIT = 3072,
    parameter  int SMALL_QUICK = 6,
    parameter  int SMALL_SLOW  = 2,
    localparam int CW          = $clog2(CNT_PER_BIT)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          fast_i,
    input logic          rt_i,
    input logic          rd_i,
    input logic [CW-1:0] cnt_i,
    input logic          edge_i,
    input logic [CW-1:0] mag_i,
    input logic [CW-1:0] step_i
);

    localparam int          HALF      = CNT_PER_BIT / 2;
    localparam int          SMALL_MAX = (SMALL_QUICK > SMALL_SLOW) ? SMALL_QUICK : SMALL_SLOW;
    localparam logic [CW:0] WRAP      = (CW+1)'(CNT_PER_BIT);

    assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, cnt_i} < WRAP)
        else $error("phase counter out of range");

    assert_rd_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rd_i) |-> $fell(rt_i))
        else $error("retimed data moved away from the clock fall");

    assert_retard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_i && (cnt_i < CW'(HALF)) && (cnt_i != '0)) |=> (cnt_i <= $past(cnt_i)))
        else $error("early-half transition did not retard the counter");

    assert_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_i && (cnt_i >= CW'(HALF))) |=>
            ({1'b0, cnt_i} != (({1'b0, $past(cnt_i)} + 1'b1) % WRAP)))
        else $error("late-half transition did not advance the counter");

    assert_small_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_i && !fast_i) |-> (step_i <= CW'(SMALL_MAX)))
        else $error("large step taken with fast correction off");

    assert_no_overshoot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |-> (step_i <= mag_i))
        else $error("correction larger than the measured error");

endmodule

bind bit_timing_dpll bit_timing_dpll_chk #(
    .CNT_PER_BIT (CNT_PER_BIT),
    .SMALL_QUICK (SMALL_QUICK),
    .SMALL_SLOW  (SMALL_SLOW)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (fast_corr_i),
    .rt_i   (rt_o),
    .rd_i   (rd_o),
    .cnt_i  (cnt_q),
    .edge_i (edge_s),
    .mag_i  (err_mag),
    .step_i (corr_step)
);

// File: tb/bit_timing_dpll_test.sv
`timescale 1ns/1ps
module bit_timing_dpll_test;

    localparam int N     = 768;
    localparam int HALF  = N / 2;
    localparam int WIN   = N / 16;
    localparam int SQ    = 6;
    localparam int SS    = 2;
    localparam int WATCH = 190000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic rx    = 1'b0;
    logic fast  = 1'b1;
    logic slow  = 1'b0;
    logic rt;
    logic rd;

    always #2 clk = ~clk;

    bit_timing_dpll #(
        .CNT_PER_BIT (N)
    ) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_bit_i    (rx),
        .fast_corr_i (fast),
        .slow_lock_i (slow),
        .rt_o        (rt),
        .rd_o        (rd)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    int   j        = 0;
    logic rt_prev  = 1'b1;
    logic rd_prev  = 1'b0;
    logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
    bit   rise = 1'b0, fall = 1'b0, done = 1'b0;

    function automatic int exp_span(int c, bit f, bit s);
        int m, st;
        m = (c < HALF) ? c : N - c;
        if (f && m > WIN) st = m >> 3;
        else              st = s ? SS : SQ;
        if (st > m) st = m;
        return (c < HALF) ? 2 * N + st : 2 * N - st;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One master cycle: observe outputs at the falling edge, keep input history
    task automatic tick();
        h3 = h2; h2 = h1; h1 = rx;
        @(negedge clk);
        rise = rt && !rt_prev;
        fall = !rt && rt_prev;
        if (rise) j = 0; else j++;
        if (fall) check(rd === h3, "R3 rd at clock fall", int'(rd), int'(h3));
        if (rd !== rd_prev) check(fall, "R2 rd change off the fall", int'(fall), 1);
        rt_prev = rt;
        rd_prev = rd;
    endtask

    task automatic wait_rise();
        do tick(); while (!rise);
    endtask

    // Single transition at d cycles after an rt rise; measure the two-bit span
    task automatic one_shot(int d, bit f, bit s, string tag);
        int span, r, c, e;
        fast = f; slow = s;
        wait_rise();
        span = 0;
        repeat (d) begin tick(); span++; end
        rx = ~rx;
        c = d + 2;
        r = 0;
        while (r < 2) begin
            tick(); span++;
            if (rise) r++;
        end
        e = exp_span(c, f, s);
        check(span == e, tag, span, e);
    endtask

    // Alternating pattern at the nominal rate; error must sit in the window from chk_at on
    task automatic lock_run(int off, bit f, bit s, int nbits, int chk_at, string tag);
        int c, m;
        fast = f; slow = s;
        wait_rise();
        repeat (off) tick();
        for (int i = 1; i <= nbits; i++) begin
            c = (j + 2) % N;
            m = (c < HALF) ? c : N - c;
            if (i >= chk_at) check(m <= WIN + 1, tag, m, WIN);
            rx = ~rx;
            repeat (N) tick();
        end
    endtask

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d cycles", WATCH, WATCH - 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int t, d, sd;
        bit f, s;
        sd = $urandom(32'd1200);
        // R11: reset state
        repeat (5) @(negedge clk);
        check(rt === 1'b1, "R11 rt in reset", int'(rt), 1);
        check(rd === 1'b0, "R11 rd in reset", int'(rd), 0);
        rst_n = 1'b1;
        j = 0;

        // R1: free-running period and high time
        wait_rise();
        t = 0;
        do begin tick(); t++; end while (!fall);
        check(t == HALF, "R1 high time", t, HALF);
        do begin tick(); t++; end while (!rise);
        check(t == N, "R1 period", t, N);

        // Directed corner cases (R4 locates c = d + 2)
        one_shot(WIN - 2, 1'b1, 1'b1, "R7 R4 window edge small step");
        one_shot(WIN - 1, 1'b1, 1'b1, "R6 just outside window");
        one_shot(300,     1'b0, 1'b0, "R8 fast off big error");
        one_shot(300,     1'b1, 1'b0, "R6 R5 retard large");
        one_shot(N - 3,   1'b1, 1'b0, "R9 step clamped to error");
        one_shot(HALF - 3, 1'b1, 1'b1, "R5 last retard count");
        one_shot(HALF - 2, 1'b1, 1'b1, "R5 first advance count");
        one_shot(0,       1'b0, 1'b0, "R9 clamp near wrap");
        one_shot(500,     1'b0, 1'b1, "R8 R9 slow small advance");
        one_shot(N - 60,  1'b1, 1'b0, "R6 advance large");

        // Random single transitions
        for (int k = 0; k < 16; k++) begin
            d = $urandom_range(0, N - 3);
            f = 1'($urandom_range(0, 1));
            s = 1'($urandom_range(0, 1));
            one_shot(d, f, s, "R4 R5 random shot");
        end

        // R10: lock-in profiles
        lock_run(370,     1'b1, 1'b0, 21, 18, "R10 quick profile retard side");
        lock_run(N - 300, 1'b1, 1'b0, 21, 18, "R10 quick profile advance side");
        lock_run(370,     1'b1, 1'b1, 53, 50, "R10 steady profile");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule